// File: doc/BRIEF.md
# Criticality-steered response splitter

This block sits on the response side of a cache bank. It takes one whole-block response and sends it out on two physical networks. The block holds sixteen 32-bit words. Two per-word vectors travel with the response: a criticality vector and a liveness vector, both taken from the original request. Words that are both critical and live go in a packet on the critical network. Live words that are not critical go in a packet on the non-critical network. Dead words are sent on neither network.

Packets that carry no block data are routed by type alone. Control traffic, such as requests, invalidations and acknowledgements, goes on the critical network. Writebacks go on the non-critical network.

Each output is a word-serial stream with a valid/ready handshake.
- A packet starts with a header beat. The header carries the block address, the packet type and a 16-bit word mask, so the receiver can set one valid bit per word.
- The data words follow the header, one per beat, in ascending offset order.
- The input side also uses valid/ready. A response is accepted only when both output packets from the previous response have fully drained.
- Once a response has been latched, the two outputs run on their own. Back-pressure on one output never holds up the other.

Top module: `crit_resp_splitter`

## Requirements
- R1: `in_ready` is high exactly when neither output has a packet in flight. After reset, `in_ready` is high and both output valids are low.
- R2: For a data response (`in_kind` = 2'b00), the critical packet's word mask is `in_crit & in_live`. Bit i of the mask stands for word i, which is held at `in_words[32*i +: 32]`.
- R3: For a data response, the non-critical packet's word mask is `~in_crit & in_live`. A word whose liveness bit is 0 appears in neither packet.
- R4: A packet is one header beat (`head` = 1, data 0), followed by one beat for each mask bit that is set, in ascending word offset. `last` is high only on the final beat.
- R5: A data packet whose mask is all zero is not sent at all. No header-only data packet appears on either network.
- R6: A control response (`in_kind` 2'b01 or 2'b11) produces one header beat on the critical network, with mask 0 and `last` = 1. Nothing appears on the non-critical network.
- R7: A writeback (`in_kind` = 2'b10) produces a non-critical packet with mask 16'hFFFF and all 16 words, whatever the two vectors hold. Nothing appears on the critical network.
- R8: While an output has valid high and ready low, valid stays high and `head`, `last` and `data` stay unchanged on the next cycle.
- R9: Holding one output's ready low does not stop the other output from sending its whole packet. Meanwhile `in_ready` stays low.
- R10: The header beat carries the accepted block address and the accepted `in_kind` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A response is offered |
| in_ready | output | 1 | Splitter can accept a response |
| in_kind | input | 2 | 00 data, 10 writeback, 01/11 control |
| in_addr | input | 26 | Block address |
| in_words | input | 512 | Sixteen 32-bit words, word i at bits 32*i+31:32*i |
| in_crit | input | 16 | Per-word criticality prediction |
| in_live | input | 16 | Per-word liveness prediction |
| cn_valid | output | 1 | Critical network beat valid |
| cn_ready | input | 1 | Critical network accepts the beat |
| cn_head | output | 1 | Beat is a header |
| cn_last | output | 1 | Final beat of the packet |
| cn_addr | output | 26 | Block address (meaningful on header) |
| cn_kind | output | 2 | Packet type (meaningful on header) |
| cn_mask | output | 16 | Word mask (meaningful on header) |
| cn_data | output | 32 | Data word (0 on header) |
| nn_valid | output | 1 | Non-critical network beat valid |
| nn_ready | input | 1 | Non-critical network accepts the beat |
| nn_head | output | 1 | Beat is a header |
| nn_last | output | 1 | Final beat of the packet |
| nn_addr | output | 26 | Block address (meaningful on header) |
| nn_kind | output | 2 | Packet type (meaningful on header) |
| nn_mask | output | 16 | Word mask (meaningful on header) |
| nn_data | output | 32 | Data word (0 on header) |

## Verification
The bench aims at the corner cases of this block.

Responses whose critical or non-critical share is empty, or where both shares are empty, catch a splitter that sends a stray header or that waits for a packet which never comes. A single word at offset 15 exposes errors in the skip-to-next-word logic, which would show up as a wrong `last` or a wrong word. Writebacks and control packets are sent with vectors chosen to mislead, so that steering by vector instead of by type shows up on the wrong network.

Random-pattern stalls and a fully held non-critical ready check two more faults: payload that changes while stalled, and one network stalling the other.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;
  localparam int unsigned KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    K_DATA = 2'b00,
    K_CTRL = 2'b01,
    K_WB   = 2'b10,
    K_CTL2 = 2'b11
  } kind_e;
endpackage

// File: rtl/steer_decode.sv
`timescale 1ns/1ps
module steer_decode
  import crs_pkg::*;
#(
  parameter int unsigned NW = 16
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [NW-1:0]     crit,
  input  logic [NW-1:0]     live,
  output logic              c_en,
  output logic [NW-1:0]     c_mask,
  output logic              n_en,
  output logic [NW-1:0]     n_mask
);
  logic is_data, is_wb;

  always_comb begin
    is_data = (kind == K_DATA);
    is_wb   = (kind == K_WB);
    if (is_data) begin
      c_mask = crit & live;
      n_mask = ~crit & live;
      c_en   = |c_mask;
      n_en   = |n_mask;
    end else if (is_wb) begin
      c_mask = '0;
      n_mask = '1;
      c_en   = 1'b0;
      n_en   = 1'b1;
    end else begin
      c_mask = '0;
      n_mask = '0;
      c_en   = 1'b1;
      n_en   = 1'b0;
    end
  end
endmodule

// File: rtl/split_lane.sv
`timescale 1ns/1ps
module split_lane #(
  parameter int unsigned NW = 16,
  parameter int unsigned WW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_en,
  input  logic [NW-1:0]    load_mask,
  input  logic [NW*WW-1:0] words,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_head,
  output logic             out_last,
  output logic [NW-1:0]    out_mask,
  output logic [WW-1:0]    out_data
);
  localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [NW-1:0] ONE = NW'(1);

  logic          busy, at_head;
  logic [NW-1:0] rem, mask_q, rem_next;
  logic [IW-1:0] idx;

  function automatic logic [IW-1:0] lowest_set(input logic [NW-1:0] v);
    lowest_set = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = IW'(i);
    end
  endfunction

  always_comb begin
    idx      = lowest_set(rem);
    rem_next = rem & (rem - ONE);
    out_valid = busy;
    out_head  = at_head;
    out_mask  = mask_q;
    out_last  = at_head ? (rem == '0) : (rem_next == '0);
    out_data  = at_head ? '0 : words[idx*WW +: WW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      at_head <= 1'b0;
      rem     <= '0;
      mask_q  <= '0;
    end else if (load) begin
      busy    <= load_en;
      at_head <= 1'b1;
      rem     <= load_mask;
      mask_q  <= load_mask;
    end else if (busy && out_ready) begin
      if (at_head) begin
        at_head <= 1'b0;
        if (rem == '0) busy <= 1'b0;
      end else begin
        rem <= rem_next;
        if (rem_next == '0) busy <= 1'b0;
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_head) && $stable(out_last));

  // R4
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  // R4
  data_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_head |=> (mask_q & ~rem) != '0 || load);
endmodule

// File: rtl/crit_resp_splitter.sv
`timescale 1ns/1ps
module crit_resp_splitter
  import crs_pkg::*;
#(
  parameter int unsigned NW = 16,
  parameter int unsigned WW = 32,
  parameter int unsigned AW = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [AW-1:0]    in_addr,
  input  logic [NW*WW-1:0] in_words,
  input  logic [NW-1:0]    in_crit,
  input  logic [NW-1:0]    in_live,
  output logic             cn_valid,
  input  logic             cn_ready,
  output logic             cn_head,
  output logic             cn_last,
  output logic [AW-1:0]    cn_addr,
  output logic [1:0]       cn_kind,
  output logic [NW-1:0]    cn_mask,
  output logic [WW-1:0]    cn_data,
  output logic             nn_valid,
  input  logic             nn_ready,
  output logic             nn_head,
  output logic             nn_last,
  output logic [AW-1:0]    nn_addr,
  output logic [1:0]       nn_kind,
  output logic [NW-1:0]    nn_mask,
  output logic [WW-1:0]    nn_data
);
  localparam int unsigned NL = 2;

  logic [NW*WW-1:0] words_q;
  logic [AW-1:0]    addr_q;
  logic [1:0]       kind_q;
  logic [NW-1:0]    live_q;
  logic             accept;

  logic [NL-1:0]         l_en, l_valid, l_ready, l_head, l_last;
  logic [NL-1:0][NW-1:0] l_mask_in, l_mask;
  logic [NL-1:0][WW-1:0] l_data;

  steer_decode #(.NW(NW)) u_dec (
    .kind   (in_kind),
    .crit   (in_crit),
    .live   (in_live),
    .c_en   (l_en[0]),
    .c_mask (l_mask_in[0]),
    .n_en   (l_en[1]),
    .n_mask (l_mask_in[1])
  );

  assign in_ready = ~|l_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q <= '0;
      addr_q  <= '0;
      kind_q  <= '0;
      live_q  <= '0;
    end else if (accept) begin
      words_q <= in_words;
      addr_q  <= in_addr;
      kind_q  <= in_kind;
      live_q  <= in_live;
    end
  end

  assign l_ready = {nn_ready, cn_ready};

  for (genvar g = 0; g < NL; g++) begin : g_lane
    split_lane #(.NW(NW), .WW(WW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_en   (l_en[g]),
      .load_mask (l_mask_in[g]),
      .words     (words_q),
      .out_valid (l_valid[g]),
      .out_ready (l_ready[g]),
      .out_head  (l_head[g]),
      .out_last  (l_last[g]),
      .out_mask  (l_mask[g]),
      .out_data  (l_data[g])
    );
  end

  assign cn_valid = l_valid[0];
  assign cn_head  = l_head[0];
  assign cn_last  = l_last[0];
  assign cn_mask  = l_mask[0];
  assign cn_data  = l_data[0];
  assign cn_addr  = addr_q;
  assign cn_kind  = kind_q;
  assign nn_valid = l_valid[1];
  assign nn_head  = l_head[1];
  assign nn_last  = l_last[1];
  assign nn_mask  = l_mask[1];
  assign nn_data  = l_data[1];
  assign nn_addr  = addr_q;
  assign nn_kind  = kind_q;

  // R1
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !cn_valid && !nn_valid);

  // R3
  disjoint_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cn_valid && nn_valid |-> (cn_mask & nn_mask) == '0);

  // R3
  dead_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind_q == K_DATA && (cn_valid || nn_valid) |-> ((cn_mask | nn_mask) & ~live_q) == '0);

  // R7
  wb_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind_q == K_WB && nn_valid |-> nn_mask == '1 && !cn_valid);

  // R6
  ctrl_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_CTRL || kind_q == K_CTL2) && cn_valid |-> cn_head && cn_last && !nn_valid);
endmodule

// File: tb/tb_crit_resp_splitter.sv
`timescale 1ns/1ps
module tb_crit_resp_splitter;
  localparam int NW = 16;
  localparam int WW = 32;
  localparam int AW = 26;
  localparam int NV = 9;

  // {kind, crit, live}
  localparam logic [33:0] VEC [NV] = '{
    {2'b00, 16'h0001, 16'hFFFF},
    {2'b00, 16'h00A4, 16'h0FF4},
    {2'b00, 16'hFFFF, 16'hFFFF},
    {2'b00, 16'h0000, 16'h8001},
    {2'b00, 16'h1234, 16'h0000},
    {2'b01, 16'hFFFF, 16'hFFFF},
    {2'b10, 16'hFFFF, 16'h0000},
    {2'b11, 16'h0000, 16'h0000},
    {2'b00, 16'h8000, 16'h8000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, cn_ready = 1'b0, nn_ready = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = '0;
  logic [AW-1:0] in_addr = '0;
  logic [NW*WW-1:0] in_words = '0;
  logic [NW-1:0] in_crit = '0, in_live = '0;
  logic cn_valid, cn_head, cn_last, nn_valid, nn_head, nn_last;
  logic [AW-1:0] cn_addr, nn_addr;
  logic [1:0] cn_kind, nn_kind;
  logic [NW-1:0] cn_mask, nn_mask;
  logic [WW-1:0] cn_data, nn_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crit_resp_splitter #(.NW(NW), .WW(WW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_addr(in_addr), .in_words(in_words),
    .in_crit(in_crit), .in_live(in_live),
    .cn_valid(cn_valid), .cn_ready(cn_ready), .cn_head(cn_head), .cn_last(cn_last),
    .cn_addr(cn_addr), .cn_kind(cn_kind), .cn_mask(cn_mask), .cn_data(cn_data),
    .nn_valid(nn_valid), .nn_ready(nn_ready), .nn_head(nn_head), .nn_last(nn_last),
    .nn_addr(nn_addr), .nn_kind(nn_kind), .nn_mask(nn_mask), .nn_data(nn_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [WW-1:0] word_of(input logic [AW-1:0] a, input int i);
    return {a[15:0] ^ 16'h3C00, 8'hA5, 3'b000, 5'(i)};
  endfunction

  // model from R2, R3, R5, R6, R7
  function automatic logic [NW-1:0] exp_mask(input int lane, input logic [1:0] k,
                                             input logic [NW-1:0] c, input logic [NW-1:0] l);
    if (k == 2'b00) return (lane == 0) ? (c & l) : (~c & l);
    if (k == 2'b10) return (lane == 1) ? 16'hFFFF : 16'h0000;
    return 16'h0000;
  endfunction

  function automatic int exp_beats(input int lane, input logic [1:0] k,
                                   input logic [NW-1:0] c, input logic [NW-1:0] l);
    logic [NW-1:0] m;
    m = exp_mask(lane, k, c, l);
    if (k == 2'b00) return (m == 0) ? 0 : 1 + $countones(m);
    if (k == 2'b10) return (lane == 1) ? 1 + NW : 0;
    return (lane == 0) ? 1 : 0;
  endfunction

  function automatic int nth_set(input logic [NW-1:0] m, input int n);
    int cnt;
    cnt = 0;
    for (int i = 0; i < NW; i++) begin
      if (m[i]) begin
        if (cnt == n) return i;
        cnt++;
      end
    end
    return -1;
  endfunction

  function automatic string tag_of(input int lane, input logic [1:0] k);
    if (k == 2'b10) return "R7 writeback";
    if (k != 2'b00) return "R6 control";
    return (lane == 0) ? "R2 R4 critical" : "R3 R4 noncritical";
  endfunction

  task automatic check_beat(input int lane, input int k, input int nexp, input logic [NW-1:0] m,
                            input logic [1:0] kd, input logic [AW-1:0] a,
                            input logic hd, input logic ls, input logic [AW-1:0] oa,
                            input logic [1:0] ok, input logic [NW-1:0] om, input logic [WW-1:0] od);
    string t;
    t = tag_of(lane, kd);
    if (k >= nexp) begin
      chk(1'b0, {t, " R5 extra beat"}, 64'(k), 64'(nexp));
    end else if (k == 0) begin
      chk(hd && ls == (nexp == 1) && om == m && od == '0, {t, " header"},
          {hd, ls, om, od}, {1'b1, nexp == 1, m, 32'h0});
      chk(oa == a && ok == kd, "R10 header addr/kind", {ok, oa}, {kd, a});
    end else begin
      chk(!hd && ls == (k == nexp - 1) && od == word_of(a, nth_set(m, k - 1)), {t, " data beat"},
          {hd, ls, od}, {1'b0, k == nexp - 1, word_of(a, nth_set(m, k - 1))});
    end
  endtask

  task automatic run_case(input logic [1:0] kd, input logic [NW-1:0] c, input logic [NW-1:0] l,
                          input logic [AW-1:0] a, input bit stall, input bit hold_n);
    int ec, en, sc, sn;
    logic [NW-1:0] mc, mn;
    bit pc, pn, hold_seen;
    logic [WW+1:0] dc, dn;
    ec = exp_beats(0, kd, c, l); en = exp_beats(1, kd, c, l);
    mc = exp_mask(0, kd, c, l);  mn = exp_mask(1, kd, c, l);
    sc = 0; sn = 0; pc = 0; pn = 0; hold_seen = 0; dc = '0; dn = '0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_kind = kd; in_crit = c; in_live = l; in_addr = a;
    for (int i = 0; i < NW; i++) in_words[i*WW +: WW] = word_of(a, i);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int t = 0; t < 200; t++) begin
      if (sc >= ec && sn >= en && !cn_valid && !nn_valid) break;
      if (pc) chk(cn_valid && {cn_head, cn_last, cn_data} == dc, "R8 crit hold", {cn_valid, cn_head, cn_last, cn_data}, {1'b1, dc});
      if (pn) chk(nn_valid && {nn_head, nn_last, nn_data} == dn, "R8 noncrit hold", {nn_valid, nn_head, nn_last, nn_data}, {1'b1, dn});
      cn_ready = stall ? ((t % 3) != 1) : 1'b1;
      if (hold_n && sc < ec) nn_ready = 1'b0;
      else nn_ready = stall ? ((t % 4) != 2) : 1'b1;
      if (hold_n && sc == ec && !hold_seen) begin
        hold_seen = 1;
        chk(sn == 0 && nn_valid && !cn_valid && !in_ready, "R9 R1 independent drain",
            {sn[7:0], nn_valid, cn_valid, in_ready}, {8'd0, 1'b1, 1'b0, 1'b0});
      end
      pc = cn_valid && !cn_ready; dc = {cn_head, cn_last, cn_data};
      pn = nn_valid && !nn_ready; dn = {nn_head, nn_last, nn_data};
      if (cn_valid && cn_ready) begin
        check_beat(0, sc, ec, mc, kd, a, cn_head, cn_last, cn_addr, cn_kind, cn_mask, cn_data);
        sc++;
      end
      if (nn_valid && nn_ready) begin
        check_beat(1, sn, en, mn, kd, a, nn_head, nn_last, nn_addr, nn_kind, nn_mask, nn_data);
        sn++;
      end
      @(negedge clk);
    end
    chk(sc == ec, (ec == 0) ? "R5 R6 no critical packet" : "R2 R4 critical beat count", 64'(sc), 64'(ec));
    chk(sn == en, (en == 0) ? "R5 R7 no noncritical packet" : "R3 R4 noncritical beat count", 64'(sn), 64'(en));
    chk(in_ready, "R1 ready after drain", 64'(in_ready), 64'd1);
    if (hold_n) chk(hold_seen, "R9 hold window reached", 64'(hold_seen), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready && !cn_valid && !nn_valid, "R1 reset state", {in_ready, cn_valid, nn_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !cn_valid && !nn_valid, "R1 idle after reset", {in_ready, cn_valid, nn_valid}, 3'b100);

    for (int v = 0; v < NV; v++) begin
      run_case(VEC[v][33:32], VEC[v][31:16], VEC[v][15:0], AW'(26'h0123400 + v * 26'h1111), v[0], 1'b0);
    end

    // R9: non-critical held off while the critical packet drains
    run_case(2'b00, 16'h000F, 16'hFFFF, 26'h2ABCDE, 1'b0, 1'b1);
    // R6 and R7 back to back under stalls
    run_case(2'b10, 16'h0F0F, 16'h00FF, 26'h1000001, 1'b1, 1'b0);
    run_case(2'b01, 16'h0000, 16'h0000, 26'h0000002, 1'b1, 1'b0);
    // R5: all-dead response leaves both outputs silent and input open
    run_case(2'b00, 16'hFFFF, 16'h0000, 26'h0333333, 1'b0, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule